// File: doc/BRIEF.md
# Change-of-State Input Interrupt Unit

This unit watches a bank of 32 digital inputs and raises a single level interrupt when a programmed pattern appears on the sixteen channels that can interrupt, channels 4 to 19. Every input passes through a two-flop synchroniser. Edges are found by comparing each synchronised sample with the sample taken one clock earlier.

Two per-channel mask registers choose the sense of each channel. The rising mask selects channels that react to a rising edge or a high level. The falling mask selects channels that react to a falling edge or a low level. One control bit chooses how the selected channels combine:

- **Edge-OR mode:** any single selected edge fires the interrupt.
- **Level-AND mode:** the interrupt fires only when every selected channel holds its level at the same time. After an acknowledge, a fresh change of level is needed before this mode can fire again.

A simple 32-bit register bus gives access to the raw inputs, both masks, the control register and the latched status.

The unit is controlled by a three-state machine:

- **ARMED:** the unit waits for a trigger. The `fire` transition leads to FIRED.
- **FIRED:** the interrupt is asserted. The `ack` transition, a control write with the enable bit clear, leads to ARMED in edge-OR mode or to BLOCKED in level-AND mode.
- **BLOCKED:** the unit waits for a level change. The `release` transition, taken on a level change of any selected channel or when edge-OR mode is selected, leads back to ARMED.

Top module: `cos_irq_unit`

## Requirements
- R1: The rising mask is at offset 0x04 and the falling mask at offset 0x08. Only bits 4..19 (mask 0x000FFFF0) are stored; every other bit reads as zero.
- R2: A read at offset 0x00 returns the input bus through a two-flop synchroniser. A change driven before a clock edge is visible after the second edge and not after the first.
- R3: The control register is at offset 0x10. Bit 2 enables the interrupt and bit 1 selects the combine mode (1 = level-AND, 0 = edge-OR). All other bits read as zero. With bit 2 clear, no interrupt is produced.
- R4: In edge-OR mode, a rising edge on a channel in the rising mask, or a falling edge on a channel in the falling mask, asserts `irq` after the third clock edge following the input change.
- R5: In level-AND mode, `irq` asserts only when every channel in either mask holds its selected level (high for the rising mask, low for the falling mask) at the same time.
- R6: After a level-AND interrupt is acknowledged, no new interrupt is produced until a selected channel changes level, even if the condition stays true.
- R7: The status register is at offset 0x0C. In edge-OR mode it holds the channels whose edges fired. In level-AND mode it holds all selected channels. A status read clears it for the next read.
- R8: A control write with bit 2 clear drops `irq` on the next cycle. Writing bit 2 set afterwards re-arms the unit.
- R9: Reset clears all registers and `irq`. While both masks are zero, no interrupt is produced in either mode.
- R10: While `irq` is pending, further input events change neither `irq` nor the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 32 | Asynchronous digital inputs |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on offset 0x0C) |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that each bus strobe lasts exactly one clock. They also assume that software writes the control register with the enable bit clear before it changes mode while an interrupt is pending. The bench drives every strobe for a single cycle from the falling edge and always acknowledges before reprogramming. It changes inputs only on falling edges, so the synchroniser latency can be counted exactly. A behavioural model tracks the interrupt line on every cycle alongside the directed register checks.

// File: rtl/cos_pkg.sv
package cos_pkg;
    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_FIRED   = 2'd1,
        ST_BLOCKED = 2'd2
    } cos_state_t;

    localparam logic [4:0] OFS_RAW  = 5'h00;
    localparam logic [4:0] OFS_RISE = 5'h04;
    localparam logic [4:0] OFS_FALL = 5'h08;
    localparam logic [4:0] OFS_STAT = 5'h0C;
    localparam logic [4:0] OFS_CTRL = 5'h10;

    localparam int CTRL_EN_BIT  = 2;
    localparam int CTRL_AND_BIT = 1;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] stage_q [STAGES];

    // Stage 0 samples the pins; each further stage follows the one before it.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    // One-cycle-old copy of the synchronised value, used for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_o <= '0;
        else        prev_o <= stage_q[STAGES-1];
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
    parameter int W  = 32,
    parameter int LO = 4,
    parameter int HI = 19
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] hit,
    output logic [W-1:0] sel,
    output logic         level_all,
    output logic         change_any
);
    logic [W-1:0] bad;
    logic [W-1:0] moved;

    // Only channels LO..HI can contribute; all others are tied off.
    generate
        for (genvar c = 0; c < W; c++) begin : g_ch
            if (c >= LO && c <= HI) begin : g_live
                assign hit[c]   = (rise_en[c] & cur[c] & ~prev[c]) |
                                  (fall_en[c] & ~cur[c] & prev[c]);
                assign sel[c]   = rise_en[c] | fall_en[c];
                assign bad[c]   = (rise_en[c] & ~cur[c]) | (fall_en[c] & cur[c]);
                assign moved[c] = sel[c] & (cur[c] ^ prev[c]);
            end else begin : g_dead
                assign hit[c]   = 1'b0;
                assign sel[c]   = 1'b0;
                assign bad[c]   = 1'b0;
                assign moved[c] = 1'b0;
            end
        end
    endgenerate

    assign level_all  = (|sel) && !(|bad);
    assign change_any = |moved;
endmodule

// File: rtl/cos_fsm.sv
module cos_fsm
    import cos_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         and_mode,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] sel,
    input  logic         level_all,
    input  logic         change_any,
    input  logic         ack,
    input  logic         stat_rd,
    output logic         irq,
    output logic [W-1:0] status
);
    cos_state_t state_q, state_d;
    logic       fire;

    // Next state: fire, ack and release transitions.
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                fire = en && (and_mode ? level_all : (|hit));
                if (fire) state_d = ST_FIRED;
            end
            ST_FIRED: begin
                if (ack) state_d = and_mode ? ST_BLOCKED : ST_ARMED;
            end
            ST_BLOCKED: begin
                if (!and_mode || change_any) state_d = ST_ARMED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Outputs: interrupt line and latched status.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq    <= 1'b0;
            status <= '0;
        end else begin
            irq <= (state_d == ST_FIRED);
            if (fire)         status <= and_mode ? sel : hit;
            else if (stat_rd) status <= '0;
        end
    end
endmodule

// File: rtl/cos_irq_unit.sv
module cos_irq_unit
    import cos_pkg::*;
#(
    parameter int NUM_IN      = 32,
    parameter int CH_LO       = 4,
    parameter int CH_HI       = 19,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] din,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    function automatic logic [NUM_IN-1:0] build_mask();
        logic [NUM_IN-1:0] m;
        m = '0;
        for (int i = CH_LO; i <= CH_HI; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [NUM_IN-1:0] CH_MASK = build_mask();

    logic [NUM_IN-1:0] din_sync, din_prev, rise_q, fall_q, hit, sel, status;
    logic              en_q, and_q, level_all, change_any;
    logic              wr_ctrl, ack, stat_rd;

    cos_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(din), .sync_o(din_sync), .prev_o(din_prev)
    );

    cos_detect #(.W(NUM_IN), .LO(CH_LO), .HI(CH_HI)) u_detect (
        .cur(din_sync), .prev(din_prev), .rise_en(rise_q), .fall_en(fall_q),
        .hit(hit), .sel(sel), .level_all(level_all), .change_any(change_any)
    );

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign ack     = wr_ctrl && !bus_wdata[CTRL_EN_BIT];
    assign stat_rd = bus_rd && (bus_addr == ADDR_W'(OFS_STAT));

    cos_fsm #(.W(NUM_IN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .and_mode(and_q),
        .hit(hit), .sel(sel), .level_all(level_all), .change_any(change_any),
        .ack(ack), .stat_rd(stat_rd), .irq(irq), .status(status)
    );

    // Programmable registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
            en_q   <= 1'b0;
            and_q  <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_RISE)) rise_q <= bus_wdata[NUM_IN-1:0] & CH_MASK;
            if (bus_addr == ADDR_W'(OFS_FALL)) fall_q <= bus_wdata[NUM_IN-1:0] & CH_MASK;
            if (wr_ctrl) begin
                en_q  <= bus_wdata[CTRL_EN_BIT];
                and_q <= bus_wdata[CTRL_AND_BIT];
            end
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_RAW))  bus_rdata = 32'(din_sync);
        if (bus_addr == ADDR_W'(OFS_RISE)) bus_rdata = 32'(rise_q);
        if (bus_addr == ADDR_W'(OFS_FALL)) bus_rdata = 32'(fall_q);
        if (bus_addr == ADDR_W'(OFS_STAT)) bus_rdata = 32'(status);
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[CTRL_EN_BIT]  = en_q;
            bus_rdata[CTRL_AND_BIT] = and_q;
        end
    end
endmodule

// File: rtl/cos_irq_chk.sv
module cos_irq_chk
    import cos_pkg::*;
#(
    parameter int W      = 32,
    parameter int LO     = 4,
    parameter int HI     = 19,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              en,
    input logic [W-1:0]      rise,
    input logic [W-1:0]      fall,
    input logic [W-1:0]      status,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata
);
    function automatic logic [W-1:0] live_mask();
        logic [W-1:0] m;
        m = '0;
        for (int i = LO; i <= HI; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [W-1:0] LIVE = live_mask();

    // R1
    mode_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise | fall) & ~LIVE) == '0);

    // R3
    en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !irq);

    // R7
    status_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> status != '0);

    // R9
    mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(rise | fall) != '0);

    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && !bus_wdata[CTRL_EN_BIT]) |=> !irq);
endmodule

bind cos_irq_unit cos_irq_chk #(.W(NUM_IN), .LO(CH_LO), .HI(CH_HI), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .en(en_q), .rise(rise_q), .fall(fall_q),
    .status(status), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/tb_cos_irq_unit.sv
`timescale 1ns/1ps
module tb_cos_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] din = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0, fails = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    cos_irq_unit dut (.clk(clk), .rst_n(rst_n), .din(din), .bus_wr(bus_wr), .bus_rd(bus_rd),
                      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    // Behavioural reference model of the interrupt line.
    logic [31:0] m_s1, m_s2, m_prev, m_rise, m_fall, m_status, t_hit, t_sel, t_bad;
    bit m_en, m_and, m_irq, t_fire;
    int m_state;   // 0 armed, 1 fired, 2 blocked

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_rise = 0; m_fall = 0; m_status = 0;
            m_en = 0; m_and = 0; m_irq = 0; m_state = 0;
        end else begin
            t_hit = (m_s2 & ~m_prev & m_rise) | (~m_s2 & m_prev & m_fall);
            t_sel = m_rise | m_fall;
            t_bad = (m_rise & ~m_s2) | (m_fall & m_s2);
            t_fire = (m_state == 0) && m_en &&
                     (m_and ? (t_sel != 0 && t_bad == 0) : (t_hit != 0));
            if (t_fire) m_status = m_and ? t_sel : t_hit;
            else if (bus_rd && bus_addr == 5'h0C) m_status = 0;
            case (m_state)
                0: if (t_fire) m_state = 1;
                1: if (bus_wr && bus_addr == 5'h10 && !bus_wdata[2]) m_state = m_and ? 2 : 0;
                default: if (!m_and || ((m_s2 ^ m_prev) & t_sel) != 0) m_state = 0;
            endcase
            m_irq = (m_state == 1);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = din;
            if (bus_wr) begin
                if (bus_addr == 5'h04) m_rise = bus_wdata & 32'h000F_FFF0;
                if (bus_addr == 5'h08) m_fall = bus_wdata & 32'h000F_FFF0;
                if (bus_addr == 5'h10) begin m_en = bus_wdata[2]; m_and = bus_wdata[1]; end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n && !done) chk("R4 R5 R6 R8 model irq", 32'(irq), 32'(m_irq));

    task automatic idle(input int n); repeat (n) @(negedge clk); endtask
    task automatic set_din(input logic [31:0] v); @(negedge clk); din = v; endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1; fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        idle(2); rst_n = 1; idle(1);
        // R9 reset state
        chk("R9 irq after reset", 32'(irq), 0);
        rd(5'h04, v); chk("R9 rise reset", v, 0);
        rd(5'h10, v); chk("R9 ctrl reset", v, 0);
        // R1 mask
        wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, v); chk("R1 rise mask", v, 32'h000F_FFF0);
        wr(5'h08, 32'h0001_000F); rd(5'h08, v); chk("R1 fall mask", v, 32'h0001_0000);
        wr(5'h04, 0); wr(5'h08, 0);
        // R3 control bits, R9 no irq with masks zero in both modes
        wr(5'h10, 32'hFFFF_FFFF); rd(5'h10, v); chk("R3 ctrl readback", v, 32'h6);
        set_din(32'h000F_FFF0); idle(6); chk("R9 zero masks AND", 32'(irq), 0);
        wr(5'h10, 32'h4);
        set_din(0); idle(6); chk("R9 zero masks OR", 32'(irq), 0);
        wr(5'h10, 0);
        // R2 synchroniser latency
        @(negedge clk); bus_addr = 5'h00;
        set_din(32'hA5A5_1234); idle(1);
        chk("R2 raw after one edge", bus_rdata, 0);
        idle(1); chk("R2 raw after two edges", bus_rdata, 32'hA5A5_1234);
        set_din(0); idle(4);
        // R4 OR rising edge
        wr(5'h04, 32'h20); wr(5'h10, 32'h4);
        set_din(32'h20); idle(2); chk("R4 not yet", 32'(irq), 0);
        idle(1); chk("R4 rising fires", 32'(irq), 1);
        rd(5'h0C, v); chk("R7 status OR", v, 32'h20);
        rd(5'h0C, v); chk("R7 status cleared", v, 0);
        // R10 further events while pending
        set_din(0); idle(4); set_din(32'h20); idle(4);
        chk("R10 irq held", 32'(irq), 1);
        rd(5'h0C, v); chk("R10 status unchanged", v, 0);
        // R8 acknowledge
        wr(5'h10, 0); chk("R8 irq dropped", 32'(irq), 0);
        wr(5'h10, 32'h4);
        // R4 falling edge, out-of-range channel ignored
        wr(5'h04, 0); wr(5'h08, 32'h1004);
        set_din(32'h1024); idle(6); chk("R4 rise on fall-only ignored", 32'(irq), 0);
        set_din(32'h1020); idle(6); chk("R4 channel 2 ignored", 32'(irq), 0);
        set_din(32'h0020); idle(3); chk("R4 falling fires", 32'(irq), 1);
        rd(5'h0C, v); chk("R7 status fall", v, 32'h1000);
        wr(5'h10, 0);
        // R3 enable clear blocks
        set_din(32'h1020); idle(4); set_din(32'h20); idle(6);
        chk("R3 disabled no irq", 32'(irq), 0);
        // R5 AND mode
        wr(5'h04, 32'h50); wr(5'h08, 32'h100); set_din(0); idle(4);
        wr(5'h10, 32'h6);
        set_din(32'h10); idle(6); chk("R5 partial no irq", 32'(irq), 0);
        set_din(32'h150); idle(6); chk("R5 fall channel high no irq", 32'(irq), 0);
        set_din(32'h50); idle(3); chk("R5 all met fires", 32'(irq), 1);
        rd(5'h0C, v); chk("R7 status AND", v, 32'h150);
        // R6 blocking after acknowledge
        wr(5'h10, 32'h2); wr(5'h10, 32'h6); idle(8);
        chk("R6 blocked while steady", 32'(irq), 0);
        set_din(32'h40); idle(6); chk("R6 released not met", 32'(irq), 0);
        set_din(32'h50); idle(3); chk("R6 refires after change", 32'(irq), 1);
        // R9 reset mid-operation
        @(negedge clk); rst_n = 0; #1 chk("R9 reset drops irq", 32'(irq), 0);
        idle(1); rst_n = 1;
        rd(5'h04, v); chk("R9 rise cleared", v, 0);
        rd(5'h10, v); chk("R9 ctrl cleared", v, 0);
        idle(2);
        done = 1;
        summary();
    end
endmodule